// File: doc/BRIEF.md
# Byte-Wide Strobe FIFO Port (Peripheral Side)

This block is the peripheral end of a byte-wide parallel port that an external master drives with asynchronous active-low read and write strobes. The block holds two 16-entry byte FIFOs. The receive FIFO holds bytes that the core offers to the master. The transmit FIFO holds bytes that the master has written. Two active-low flags tell the master whether a byte is ready to read and whether there is room to write. The core side sees a valid/ready push stream into the receive FIFO and a valid/ready pop stream out of the transmit FIFO.

All three strobes from the master are treated as asynchronous. Read, write and send-now each pass through a two-flop synchroniser and an edge detector, so each edge acts exactly once. The block drives the shared bus only while the read strobe is low. A falling edge on the send-now strobe becomes a single-cycle flush request to the core-side packetiser, which then ships its partial buffer regardless of size.

The read flag is produced by a state machine with five states:
- RX_EMPTY moves to RX_AVAIL once data is present.
- RX_AVAIL moves to RX_BUSY on a read fall.
- RX_EMPTY, RX_AVAIL and RX_BUSY all move to RX_HOLD1 on a read rise, which pops the head byte.
- RX_HOLD1 always moves to RX_HOLD2.
- RX_HOLD2 moves to RX_AVAIL if bytes remain, otherwise to RX_EMPTY.

The flag is low only in RX_AVAIL and RX_BUSY.

Top module: `strobe_fifo_port`

## Requirements
- R1: `avail_n_o` is 1 while the receive FIFO is empty. It is 0 once at least one byte is held and no read pop is being guarded.
- R2: While `host_rd_n_i` is 0 (and reset is released), `hbus_oe_o` is 1 and `hbus_o` carries the receive FIFO head byte. Otherwise `hbus_oe_o` is 0.
- R3: A rising read strobe pops exactly one byte when data is present. `avail_n_o` goes to 1 three clock edges after the pin rises and stays 1 for two clocks. It returns to 0 only if a byte remains.
- R4: `room_n_o` is 1 exactly when the transmit FIFO holds 16 bytes, and 0 otherwise.
- R5: A falling write strobe pushes the byte that was on `hbus_i` into the transmit FIFO. Bytes leave on `tx_pop_*` in write order, with `tx_pop_data_o` showing the oldest byte whenever `tx_pop_valid_o` is 1.
- R6: A falling write strobe while the transmit FIFO is full is dropped, and `tx_ovf_o` becomes 1. `tx_ovf_o` stays 1 until reset.
- R7: Each falling edge on `host_flush_n_i` gives exactly one cycle of `flush_req_o`, three clock edges after the pin falls. Rising edges give none.
- R8: While `rst_n` is 0, `avail_oe_o` and `room_oe_o` are 0. After reset: both enables are 1, `avail_n_o`=1, `room_n_o`=0, `tx_pop_valid_o`=0 and `tx_ovf_o`=0.
- R9: A strobe held low for many clocks acts once. A long read pops one byte and a long write pushes one byte.
- R10: `rx_push_ready_o` is 0 exactly when the receive FIFO holds 16 bytes. A push offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n_i | input | 1 | Master read strobe, active low, asynchronous |
| host_wr_n_i | input | 1 | Master write strobe, active low, asynchronous |
| host_flush_n_i | input | 1 | Master send-now strobe, active low, asynchronous |
| hbus_i | input | 8 | Shared bus as seen by the block |
| hbus_o | output | 8 | Byte driven onto the shared bus |
| hbus_oe_o | output | 1 | Bus driver enable |
| avail_n_o | output | 1 | Low when a byte can be read |
| avail_oe_o | output | 1 | Driver enable for avail_n_o |
| room_n_o | output | 1 | Low when a byte can be written |
| room_oe_o | output | 1 | Driver enable for room_n_o |
| rx_push_valid_i | input | 1 | Core offers a byte for the receive FIFO |
| rx_push_data_i | input | 8 | Byte offered by the core |
| rx_push_ready_o | output | 1 | Receive FIFO can accept a byte |
| tx_pop_valid_o | output | 1 | Transmit FIFO holds a byte |
| tx_pop_data_o | output | 8 | Oldest transmit byte |
| tx_pop_ready_i | input | 1 | Core takes the oldest transmit byte |
| flush_req_o | output | 1 | One-cycle partial-packet flush request |
| tx_ovf_o | output | 1 | Sticky transmit overflow flag |

## Verification
The hardest case to reach from the ports is the guard window after a read. A read rise must pop while bytes remain, and the flag must be observed high for exactly two cycles before it falls again. A directed sequence preloads two bytes, holds the read strobe low long enough to reach RX_BUSY, and then samples the flag edge by edge after the rise. Transmit overflow also needs sixteen writes without draining. It is driven directly, and then sixteen pops confirm that the seventeenth byte never entered. Random mixes of core pushes, reads, writes, pops and flush strobes then run against queue models in the bench.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [2:0] {
        RX_EMPTY = 3'd0,
        RX_AVAIL = 3'd1,
        RX_BUSY  = 3'd2,
        RX_HOLD1 = 3'd3,
        RX_HOLD2 = 3'd4
    } rx_state_e;

    localparam int STB_RD    = 0;
    localparam int STB_WR    = 1;
    localparam int STB_FLUSH = 2;
    localparam int STB_COUNT = 3;
endpackage

// File: rtl/spf_sync_edge.sv
module spf_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_i};
        end
    end

    assign level_o = chain_q[LAST-1];
    assign rise_o  = chain_q[LAST-1] & ~chain_q[LAST];
    assign fall_o  = ~chain_q[LAST-1] & chain_q[LAST];
endmodule

// File: rtl/spf_fifo.sv
module spf_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             do_push, do_pop;

    assign full_o  = (count_q == FULL_CNT);
    assign empty_o = (count_q == '0);
    assign do_push = push_i & ~full_o;
    assign do_pop  = pop_i & ~empty_o;
    assign head_o  = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/spf_rx_flag_fsm.sv
module spf_rx_flag_fsm
    import spf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fall_i,
    input  logic rd_rise_i,
    input  logic nonempty_i,
    output logic avail_n_o
);
    rx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: begin
                if (rd_rise_i)       state_d = RX_HOLD1;
                else if (nonempty_i) state_d = RX_AVAIL;
            end
            RX_AVAIL: begin
                if (rd_rise_i)      state_d = RX_HOLD1;
                else if (rd_fall_i) state_d = RX_BUSY;
            end
            RX_BUSY: begin
                if (rd_rise_i) state_d = RX_HOLD1;
            end
            RX_HOLD1: state_d = RX_HOLD2;
            RX_HOLD2: state_d = nonempty_i ? RX_AVAIL : RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RX_AVAIL, RX_BUSY: avail_n_o = 1'b0;
            default:           avail_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port
    import spf_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd_n_i,
    input  logic             host_wr_n_i,
    input  logic             host_flush_n_i,
    input  logic [WIDTH-1:0] hbus_i,
    output logic [WIDTH-1:0] hbus_o,
    output logic             hbus_oe_o,
    output logic             avail_n_o,
    output logic             avail_oe_o,
    output logic             room_n_o,
    output logic             room_oe_o,
    input  logic             rx_push_valid_i,
    input  logic [WIDTH-1:0] rx_push_data_i,
    output logic             rx_push_ready_o,
    output logic             tx_pop_valid_o,
    output logic [WIDTH-1:0] tx_pop_data_o,
    input  logic             tx_pop_ready_i,
    output logic             flush_req_o,
    output logic             tx_ovf_o
);
    logic [STB_COUNT-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
    logic [WIDTH-1:0]     bus_pipe_q [SYNC_STAGES];
    logic                 rx_full, rx_empty, tx_full, tx_empty;
    logic                 rx_pop, tx_push;
    logic                 oe_q, flush_q, ovf_q;

    assign stb_raw[STB_RD]    = host_rd_n_i;
    assign stb_raw[STB_WR]    = host_wr_n_i;
    assign stb_raw[STB_FLUSH] = host_flush_n_i;

    for (genvar g = 0; g < STB_COUNT; g++) begin : g_sync
        spf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (stb_raw[g]),
            .level_o (stb_lvl[g]),
            .rise_o  (stb_rise[g]),
            .fall_o  (stb_fall[g])
        );
    end

    // Bus byte travels beside the write strobe so it lines up with the edge.
    always_ff @(posedge clk) begin
        bus_pipe_q[0] <= hbus_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            bus_pipe_q[i] <= bus_pipe_q[i-1];
        end
    end

    assign rx_pop  = stb_rise[STB_RD] & ~rx_empty;
    assign tx_push = stb_fall[STB_WR];

    spf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_push_valid_i),
        .push_data_i (rx_push_data_i),
        .pop_i       (rx_pop),
        .head_o      (hbus_o),
        .full_o      (rx_full),
        .empty_o     (rx_empty)
    );

    spf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (tx_push),
        .push_data_i (bus_pipe_q[SYNC_STAGES-1]),
        .pop_i       (tx_pop_ready_i),
        .head_o      (tx_pop_data_o),
        .full_o      (tx_full),
        .empty_o     (tx_empty)
    );

    spf_rx_flag_fsm u_rx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fall_i  (stb_fall[STB_RD]),
        .rd_rise_i  (stb_rise[STB_RD]),
        .nonempty_i (~rx_empty),
        .avail_n_o  (avail_n_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            flush_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            oe_q    <= 1'b1;
            flush_q <= stb_fall[STB_FLUSH];
            if (tx_push && tx_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign hbus_oe_o       = rst_n & ~host_rd_n_i;
    assign avail_oe_o      = oe_q;
    assign room_oe_o       = oe_q;
    assign room_n_o        = tx_full;
    assign rx_push_ready_o = ~rx_full;
    assign tx_pop_valid_o  = ~tx_empty;
    assign flush_req_o     = flush_q;
    assign tx_ovf_o        = ovf_q;

    // The synchronised read level is only used through its edges.
    logic unused_lvl;
    assign unused_lvl = ^stb_lvl;
endmodule

// File: rtl/spf_checker.sv
module spf_checker (
    input logic clk,
    input logic rst_n,
    input logic host_rd_n_i,
    input logic hbus_oe_o,
    input logic avail_n_o,
    input logic avail_oe_o,
    input logic room_n_o,
    input logic room_oe_o,
    input logic tx_pop_valid_o,
    input logic flush_req_o,
    input logic tx_ovf_o
);
    // R2: no bus drive while the read strobe is high
    a_r2_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_n_i |-> !hbus_oe_o);

    // R3: the read flag, once raised, is held for a second cycle
    a_r3_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_n_o) |=> avail_n_o);

    // R4: a full transmit FIFO is never empty
    a_r4_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        !room_n_o || tx_pop_valid_o);

    // R6: overflow stays set
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf_o |=> tx_ovf_o);

    // R7: a flush request lasts a single cycle
    a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |=> !flush_req_o);

    // R8: both flag drivers switch on together and remain on
    a_r8_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        avail_oe_o == room_oe_o);
    a_r8_oe_stay: assert property (@(posedge clk) disable iff (!rst_n)
        avail_oe_o |=> avail_oe_o);
endmodule

bind strobe_fifo_port spf_checker u_spf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_rd_n_i    (host_rd_n_i),
    .hbus_oe_o      (hbus_oe_o),
    .avail_n_o      (avail_n_o),
    .avail_oe_o     (avail_oe_o),
    .room_n_o       (room_n_o),
    .room_oe_o      (room_oe_o),
    .tx_pop_valid_o (tx_pop_valid_o),
    .flush_req_o    (flush_req_o),
    .tx_ovf_o       (tx_ovf_o)
);

// File: tb/strobe_fifo_port_tb_top.sv
module strobe_fifo_port_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd_n = 1'b1, host_wr_n = 1'b1, host_flush_n = 1'b1;
    logic [7:0] hbus_in = '0, hbus_out;
    logic       hbus_oe, avail_n, avail_oe, room_n, room_oe;
    logic       rx_valid = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic       tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       flush_req, tx_ovf;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit exp_ovf = 1'b0;

    always #5 clk = ~clk;

    strobe_fifo_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_rd_n_i(host_rd_n), .host_wr_n_i(host_wr_n), .host_flush_n_i(host_flush_n),
        .hbus_i(hbus_in), .hbus_o(hbus_out), .hbus_oe_o(hbus_oe),
        .avail_n_o(avail_n), .avail_oe_o(avail_oe),
        .room_n_o(room_n), .room_oe_o(room_oe),
        .rx_push_valid_i(rx_valid), .rx_push_data_i(rx_data), .rx_push_ready_o(rx_ready),
        .tx_pop_valid_o(tx_valid), .tx_pop_data_o(tx_data), .tx_pop_ready_i(tx_ready),
        .flush_req_o(flush_req), .tx_ovf_o(tx_ovf)
    );

    function automatic bit exp_avail_n(int n);
        return (n == 0);
    endfunction

    function automatic bit exp_room_n(int n);
        return (n == DEPTH);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic core_push(input logic [7:0] b);
        bit exp_rdy;
        exp_rdy = (rxq.size() < DEPTH);
        rx_valid = 1'b1;
        rx_data  = b;
        chk(rx_ready == exp_rdy, "R10 push ready", rx_ready, exp_rdy);
        tick(1);
        rx_valid = 1'b0;
        if (exp_rdy) rxq.push_back(b);
        tick(2);
        chk(avail_n == exp_avail_n(rxq.size()), "R1 flag after push", avail_n, exp_avail_n(rxq.size()));
    endtask

    task automatic host_read();
        host_rd_n = 1'b0;
        #1;
        chk(hbus_oe == 1'b1, "R2 bus enable", hbus_oe, 1);
        if (rxq.size() > 0)
            chk(hbus_out == rxq[0], "R2 bus byte", hbus_out, rxq[0]);
        tick(5);
        host_rd_n = 1'b1;
        #1;
        chk(hbus_oe == 1'b0, "R2 bus released", hbus_oe, 0);
        tick(6);
        if (rxq.size() > 0) void'(rxq.pop_front());
        chk(avail_n == exp_avail_n(rxq.size()), "R3 flag after read", avail_n, exp_avail_n(rxq.size()));
    endtask

    task automatic host_write(input logic [7:0] b);
        hbus_in   = b;
        host_wr_n = 1'b0;
        tick(6);
        host_wr_n = 1'b1;
        tick(3);
        if (txq.size() < DEPTH) txq.push_back(b);
        else exp_ovf = 1'b1;
        chk(room_n == exp_room_n(txq.size()), "R4 room flag", room_n, exp_room_n(txq.size()));
        chk(tx_ovf == exp_ovf, "R6 overflow flag", tx_ovf, exp_ovf);
    endtask

    task automatic core_pop();
        bit exp_v;
        exp_v = (txq.size() > 0);
        chk(tx_valid == exp_v, "R5 pop valid", tx_valid, exp_v);
        if (exp_v) begin
            chk(tx_data == txq[0], "R5 pop data order", tx_data, txq[0]);
            tx_ready = 1'b1;
            tick(1);
            tx_ready = 1'b0;
            void'(txq.pop_front());
        end
        chk(room_n == exp_room_n(txq.size()), "R4 room after pop", room_n, exp_room_n(txq.size()));
    endtask

    task automatic host_flush();
        int pulses;
        pulses = 0;
        host_flush_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (flush_req) pulses++;
        end
        chk(pulses == 1, "R7 flush on fall", pulses, 1);
        pulses = 0;
        host_flush_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (flush_req) pulses++;
        end
        chk(pulses == 0, "R7 no flush on rise", pulses, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R8 reset state
        tick(3);
        chk(avail_oe == 1'b0, "R8 avail oe in reset", avail_oe, 0);
        chk(room_oe == 1'b0, "R8 room oe in reset", room_oe, 0);
        chk(hbus_oe == 1'b0, "R8 bus off in reset", hbus_oe, 0);
        rst_n = 1'b1;
        tick(2);
        chk(avail_oe && room_oe, "R8 oe after reset", {avail_oe, room_oe}, 3);
        chk(avail_n == 1'b1, "R8 avail idle", avail_n, 1);
        chk(room_n == 1'b0, "R8 room idle", room_n, 0);
        chk(tx_valid == 1'b0, "R8 tx empty", tx_valid, 0);
        chk(tx_ovf == 1'b0, "R8 ovf clear", tx_ovf, 0);

        // R3 exact guard window with data remaining
        core_push(8'hA1);
        core_push(8'hB2);
        host_rd_n = 1'b0;
        tick(3);
        host_rd_n = 1'b1;
        tick(2);
        chk(avail_n == 1'b0, "R3 flag before pop", avail_n, 0);
        tick(1);
        chk(avail_n == 1'b1, "R3 flag high edge3", avail_n, 1);
        tick(1);
        chk(avail_n == 1'b1, "R3 flag high edge4", avail_n, 1);
        tick(1);
        chk(avail_n == 1'b0, "R3 flag back low", avail_n, 0);
        void'(rxq.pop_front());
        // R9 long read pops one byte, last byte leaves flag high
        host_read();
        host_read();

        // R10 fill receive FIFO past depth
        for (int i = 0; i < DEPTH + 1; i++) core_push(8'(i * 7 + 3));
        for (int i = 0; i < DEPTH; i++) host_read();

        // R4 / R6 / R9 fill transmit FIFO and overflow
        for (int i = 0; i < DEPTH + 1; i++) host_write(8'(8'hC0 ^ i));
        for (int i = 0; i < DEPTH + 1; i++) core_pop();

        // R7 flush strobe
        host_flush();

        // random mix
        for (int k = 0; k < 300; k++) begin
            case ($urandom_range(0, 4))
                0: core_push(8'($urandom));
                1: host_read();
                2: host_write(8'($urandom));
                3: core_pop();
                default: host_flush();
            endcase
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule